// File: doc/BRIEF.md
# Banked Interrupt Event Controller

This block collects up to 64 interrupt source lines into two banks of 32 and presents them to software through a small word-addressed register window. Each source has an event flag that is set by a rising edge on the source line while that source is enabled. An enable mask gates both the latching of events and the single interrupt request output. Software clears an event flag by writing a one to the matching bit of the bank's acknowledge word. It can read the live state of every line through a level word, whatever the mask holds.

Software picks the highest pending bit itself, so the block has no priority logic and no vector output. Turning on an enable bit while its line is already high creates no event and no request. Software has to notice such a source through the level word and handle it itself. Each bank is a copy of the same slice. The address decoder places the slice for the lower sources above the slice for the upper sources inside a 64-byte window.

Top module: `evt_irq_ctrl`

## Requirements
- R1: Byte address bits [5:4] select the bank. The value 2 selects sources 0-31 and the value 1 selects sources 32-63. The values 0 and 3 are unmapped: they read 0 and writes to them have no effect. Bits [3:2] select the word: 0 event, 1 enable, 2 acknowledge, 3 level. Bits [1:0] are ignored. Source n sits at bit n&31 of bank n>>5. Write data bit k maps to register bit k.
- R2: An event flag is set on a 0-to-1 transition of its source only if its enable bit was 1 before the clock edge. A write to the enable word in the same cycle takes effect for the next edge. A rising edge on a disabled source never sets its flag.
- R3: The enable word reads back exactly the last value written to it. It is 0 after reset.
- R4: Writing 1 to an acknowledge bit clears the matching event flag from the next cycle on. Writing 0 leaves the flag unchanged. The acknowledge word always reads 0. Writes to the event and level words have no effect.
- R5: Setting an enable bit while its source line is already high sets no event flag and leaves irq_o low.
- R6: The level word returns the current raw state of the bank's source lines, independent of the enable mask.
- R7: irq_o is high exactly when some bit has both its event flag and its enable bit set, across both banks.
- R8: When a rising edge on an enabled source and an acknowledge write of that bit fall in the same cycle, the event flag ends up set.
- R9: While rst_ni is low, all event flags, all enable bits and the stored previous source levels are cleared, and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Interrupt source lines, synchronous to clk_i |
| addr_i | input | 6 | Byte address of the register access |
| we_i | input | 1 | Write strobe for one cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the source lines are already synchronous to clk_i. They also assume that each write lasts exactly one cycle, so every cycle with we_i high counts as one separate write. The stimulus changes the sources and issues writes only just after a falling clock edge, and it holds them steady across the rising edge. Random cycles flip a sparse set of source bits and mix writes to enable, acknowledge, read-only and unmapped words. Directed cases cover three situations: an enable set on a line that is already high, an edge that collides with an acknowledge, and the address placement of the two banks.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  typedef enum logic [1:0] {
    REG_EVENT  = 2'd0,
    REG_ENABLE = 2'd1,
    REG_ACK    = 2'd2,
    REG_LEVEL  = 2'd3
  } reg_sel_e;

  localparam int BANK_SPAN_BYTES = 16;
  localparam int SLOT_LSB        = 4;

  // bank b lives in slot (NUM_BANKS - b): lower sources sit at higher offsets
  function automatic int bank_slot(input int num_banks, input int b);
    return num_banks - b;
  endfunction
endpackage

// File: rtl/evt_irq_decode.sv
module evt_irq_decode
  import evt_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 6
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_BANKS-1:0] bank_hit_o,
  output reg_sel_e             reg_sel_o
);
  localparam int SLOT_W = ADDR_W - SLOT_LSB;

  logic unused_addr_lsb;
  assign unused_addr_lsb = ^addr_i[1:0];

  assign reg_sel_o = reg_sel_e'(addr_i[3:2]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    localparam logic [SLOT_W-1:0] SLOT = SLOT_W'(bank_slot(NUM_BANKS, b));
    assign bank_hit_o[b] = (addr_i[ADDR_W-1:SLOT_LSB] == SLOT);
  end
endmodule

// File: rtl/evt_irq_bank.sv
module evt_irq_bank #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] src_i,
  input  logic             en_we_i,
  input  logic             ack_we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] event_o,
  output logic [WIDTH-1:0] enable_o,
  output logic             pend_o
);
  logic [WIDTH-1:0] src_q, event_q, enable_q;
  logic [WIDTH-1:0] latch, ack_clr, event_d;

  // latch uses the enable value held before any same-cycle write
  assign latch   = src_i & ~src_q & enable_q;
  assign ack_clr = ack_we_i ? wdata_i : '0;
  // set wins over clear
  assign event_d = (event_q & ~ack_clr) | latch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= '0;
      event_q  <= '0;
      enable_q <= '0;
    end else begin
      src_q   <= src_i;
      event_q <= event_d;
      if (en_we_i) enable_q <= wdata_i;
    end
  end

  assign event_o  = event_q;
  assign enable_o = enable_q;
  assign pend_o   = |(event_q & enable_q);

  AST_EN_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_we_i |=> enable_q == $past(wdata_i)); // R3

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_we_i |=> (event_q & $past(wdata_i) & ~$past(src_i & ~src_q & enable_q)) == '0); // R4

  AST_NO_SPURIOUS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (event_q & ~$past(event_q) & ~$past(src_i & ~src_q & enable_q)) == '0); // R2

  AST_EDGE_BEATS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($past(src_i & ~src_q & enable_q) & ~event_q) == '0); // R8
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int WORD_W    = 32,
  localparam int NUM_SRC  = NUM_BANKS * WORD_W,
  localparam int ADDR_W   = $clog2((NUM_BANKS + 2) * BANK_SPAN_BYTES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [WORD_W-1:0]  rdata_o,
  output logic               irq_o
);
  logic [NUM_BANKS-1:0] bank_hit;
  reg_sel_e             reg_sel;
  logic [WORD_W-1:0]    ev   [NUM_BANKS];
  logic [WORD_W-1:0]    en   [NUM_BANKS];
  logic [NUM_BANKS-1:0] pend;

  evt_irq_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_decode (
    .addr_i     (addr_i),
    .bank_hit_o (bank_hit),
    .reg_sel_o  (reg_sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    evt_irq_bank #(.WIDTH(WORD_W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (src_i[b*WORD_W +: WORD_W]),
      .en_we_i  (we_i && bank_hit[b] && reg_sel == REG_ENABLE),
      .ack_we_i (we_i && bank_hit[b] && reg_sel == REG_ACK),
      .wdata_i  (wdata_i),
      .event_o  (ev[b]),
      .enable_o (en[b]),
      .pend_o   (pend[b])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) begin
        unique case (reg_sel)
          REG_EVENT:  rdata_o = ev[b];
          REG_ENABLE: rdata_o = en[b];
          REG_ACK:    rdata_o = '0;
          REG_LEVEL:  rdata_o = src_i[b*WORD_W +: WORD_W];
          default:    rdata_o = '0;
        endcase
      end
    end
  end

  assign irq_o = |pend;

  AST_IRQ_LOW_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !irq_o); // R9

  AST_BANK_HIT_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_hit)); // R1
endmodule

// File: tb/tb_evt_irq_ctrl.sv
`timescale 1ns/1ps
module tb_evt_irq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] src_i = '0;
  logic [5:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  evt_irq_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .addr_i(addr_i),
    .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #2.5 clk_i = ~clk_i;

  int unsigned n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_ev [2];
  logic [31:0] m_en [2];
  logic [63:0] m_srcq;

  // R1 placement: slot 2 -> bank 0, slot 1 -> bank 1
  function automatic int bank_of(input logic [5:0] a);
    if (a[5:4] == 2'd2) return 0;
    if (a[5:4] == 2'd1) return 1;
    return -1;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [5:0] a);
    int b = bank_of(a);
    if (b < 0) return '0;
    case (a[3:2])
      2'd0: return m_ev[b];
      2'd1: return m_en[b];
      2'd2: return '0;
      default: return src_i[b*32 +: 32];
    endcase
  endfunction

  function automatic logic exp_irq();
    return |((m_ev[0] & m_en[0]) | (m_ev[1] & m_en[1]));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    addr_i = a; #0.2;
    chk(req, rdata_o, exp);
  endtask

  task automatic check_all();
    for (int b = 0; b < 2; b++) begin
      logic [5:0] base = (b == 0) ? 6'h20 : 6'h10;
      rd_chk("R2 event",  base + 6'h0, exp_rd(base + 6'h0));
      rd_chk("R3 enable", base + 6'h4, exp_rd(base + 6'h4));
      rd_chk("R4 ack",    base + 6'h8, 32'h0);
      rd_chk("R6 level",  base + 6'hC, exp_rd(base + 6'hC));
    end
    chk("R7 irq", {31'b0, irq_o}, {31'b0, exp_irq()});
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic cyc(input logic [63:0] s, input bit w, input logic [5:0] a, input logic [31:0] d);
    logic [31:0] nev [2];
    logic [31:0] nen [2];
    logic [63:0] rise;
    src_i = s; we_i = w; addr_i = a; wdata_i = d;
    rise = s & ~m_srcq;
    for (int b = 0; b < 2; b++) begin
      logic [31:0] ack = (w && bank_of(a) == b && a[3:2] == 2'd2) ? d : '0;
      nev[b] = (m_ev[b] & ~ack) | (rise[b*32 +: 32] & m_en[b]);
      nen[b] = (w && bank_of(a) == b && a[3:2] == 2'd1) ? d : m_en[b];
    end
    @(posedge clk_i);
    for (int b = 0; b < 2; b++) begin m_ev[b] = nev[b]; m_en[b] = nen[b]; end
    m_srcq = s;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] s;
    void'($urandom(32'd1234));
    m_ev[0] = '0; m_ev[1] = '0; m_en[0] = '0; m_en[1] = '0; m_srcq = '0;
    repeat (3) @(negedge clk_i);
    // R9: reset state
    check_all();
    chk("R9 irq low in reset", {31'b0, irq_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all();

    // R1: bank placement and unmapped words
    cyc('0, 1, 6'h14, 32'hFFFF_FFFF);
    cyc(64'h2 << 32, 0, 6'h00, 0);
    rd_chk("R1 upper bank at 0x10", 6'h10, 32'h2);
    rd_chk("R1 lower bank at 0x20", 6'h20, 32'h0);
    rd_chk("R1 addr lsbs ignored", 6'h17, 32'hFFFF_FFFF);
    cyc(64'h2 << 32, 1, 6'h34, 32'hFFFF_FFFF);
    cyc(64'h2 << 32, 1, 6'h04, 32'hFFFF_FFFF);
    rd_chk("R1 unmapped high reads 0", 6'h34, 32'h0);
    rd_chk("R1 unmapped low reads 0", 6'h04, 32'h0);
    rd_chk("R1 lower enable untouched", 6'h24, 32'h0);
    chk("R7 irq from upper bank", {31'b0, irq_o}, 32'h1);
    // R4: zero ack no effect, event/level writes ignored, one-ack clears
    cyc(64'h2 << 32, 1, 6'h18, 32'h0);
    cyc(64'h2 << 32, 1, 6'h10, 32'h0);
    rd_chk("R4 zero ack keeps flag", 6'h10, 32'h2);
    cyc(64'h2 << 32, 1, 6'h18, 32'h2);
    rd_chk("R4 ack clears flag", 6'h10, 32'h0);
    chk("R4 irq drops after ack", {31'b0, irq_o}, 32'h0);
    check_all();

    // R5: enable while already high
    cyc(64'h20, 0, 6'h00, 0);
    cyc(64'h20, 1, 6'h24, 32'h20);
    cyc(64'h20, 0, 6'h00, 0);
    rd_chk("R5 no event on late enable", 6'h20, 32'h0);
    rd_chk("R5 level shows line", 6'h2C, 32'h20);
    chk("R5 no irq", {31'b0, irq_o}, 32'h0);

    // R2: enable write in the same cycle as an edge uses the old mask
    cyc(64'h20, 1, 6'h24, 32'h60);
    cyc(64'h60, 1, 6'h24, 32'h00);
    rd_chk("R2 edge with old enable latches", 6'h20, 32'h40);
    cyc(64'h20, 1, 6'h28, 32'h40);
    cyc(64'h60, 0, 6'h00, 0);
    rd_chk("R2 disabled edge ignored", 6'h20, 32'h0);

    // R8: edge collides with ack
    cyc(64'h0, 1, 6'h24, 32'h80);
    cyc(64'h80, 1, 6'h28, 32'h80);
    rd_chk("R8 edge wins over ack", 6'h20, 32'h80);
    check_all();

    // random traffic
    s = 64'h0;
    for (int i = 0; i < 2000; i++) begin
      logic [5:0] a;
      logic [31:0] d;
      bit w;
      s = s ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      a = 6'($urandom);
      d = $urandom;
      if (($urandom % 4) == 0) d = d | $urandom;
      w = ($urandom % 3) != 0;
      cyc(s, w, a, d);
      check_all();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule